// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This block holds a 64-bit accumulator, kept as an upper word and a lower word, and applies one arithmetic operation to it per request. Supported operations are signed 16x16 and 32x32 multiply-accumulate, each with optional saturation chosen by a per-request mode bit. There are also multiply-only forms that replace just the lower word, full-width signed and unsigned 32x32 multiplies that replace the whole accumulator, a clear, and separate loads of either word.

A request is presented with `op_valid`, an operation code, the mode bit and two 32-bit operands. It is accepted on a rising edge where `busy` is low. The operands are registered, multiplied in a dedicated stage, and the result is written back one stage later. `done` then pulses for one cycle and the new accumulator value shows on the read ports. Both words are always readable from `acc_hi` and `acc_lo`.

Top module: `mac_unit`

## Requirements
- R1: While reset is asserted and after it is released, `acc_hi` and `acc_lo` read zero and `busy` and `done` are low until a request is accepted.
- R2: A request is accepted on a rising edge with `op_valid` high and `busy` low. `busy` is high for the two cycles after that edge. The accumulator update and a one-cycle `done` pulse appear after the third rising edge, counting the accepting edge. `op_code` values: 0 clear, 1 load upper, 2 load lower, 3 MAC16, 4 MAC32, 5 MUL32, 6 signed MUL16, 7 unsigned MUL16, 8 signed DMUL, 9 unsigned DMUL.
- R3: `op_valid` seen while `busy` is high is ignored: it yields no extra `done` and no accumulator change.
- R4: MAC16 with `sat_mode` low adds the sign-extended signed product of `op_a[15:0]` and `op_b[15:0]` to the whole 64-bit accumulator, wrapping modulo 2^64.
- R5: MAC16 with `sat_mode` high forms the signed lower word plus the product. A sum above 0x7FFFFFFF sets the upper word to 1 and the lower word to 0x7FFFFFFF.
- R6: MAC16 with `sat_mode` high and a sum below -2^31 sets the upper word to 1 and the lower word to 0x80000000. A sum in range keeps the upper word and writes the sum's low 32 bits to the lower word.
- R7: MAC32 adds the signed 64-bit product of `op_a` and `op_b` to the accumulator. With `sat_mode` low it wraps modulo 2^64. With `sat_mode` high the exact sum is clamped to the range 0xFFFF800000000000 through 0x00007FFFFFFFFFFF.
- R8: MUL32 (low 32 bits of `op_a`*`op_b`), signed MUL16 and unsigned MUL16 write the low 32 bits of the product to the lower word and leave the upper word unchanged.
- R9: Signed and unsigned DMUL replace the whole accumulator with the full 64-bit product.
- R10: Clear zeroes both words. Load upper writes `op_a` to the upper word and load lower writes `op_a` to the lower word, each leaving the other word unchanged.
- R11: Codes 10 to 15 complete with a `done` pulse and leave the accumulator unchanged.
- R12: The accumulator outputs change only in a cycle where `done` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_valid | input | 1 | Request present |
| op_code | input | 4 | Operation code (see R2) |
| sat_mode | input | 1 | Saturation enable for MAC16 and MAC32 |
| op_a | input | 32 | First operand, also load data |
| op_b | input | 32 | Second operand |
| busy | output | 1 | Request in progress; new requests are ignored |
| done | output | 1 | One-cycle pulse when the result is written |
| acc_hi | output | 32 | Upper accumulator word |
| acc_lo | output | 32 | Lower accumulator word |

## Verification
Two things can land in the same cycle: the `done` pulse and write-back of one request, and the acceptance of the next request, since `busy` is already low while `done` is high. The bench issues requests back to back, so every follow-on request is driven in its predecessor's `done` cycle. Each result is then compared against a reference value computed from the previous expected accumulator. If the retiring write-back and the new capture interfered, the next result would be off. A second case holds `op_valid` high with a clear request across the busy window, and any extra `done` or a zeroed accumulator is reported.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef enum logic [3:0] {
    OP_CLR    = 4'd0,
    OP_LDH    = 4'd1,
    OP_LDL    = 4'd2,
    OP_MAC16  = 4'd3,
    OP_MAC32  = 4'd4,
    OP_MUL32  = 4'd5,
    OP_MULS16 = 4'd6,
    OP_MULU16 = 4'd7,
    OP_DMULS  = 4'd8,
    OP_DMULU  = 4'd9
  } mac_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_MULT  = 2'd1,
    ST_WRITE = 2'd2
  } mac_state_e;
endpackage

// File: rtl/mac_ctl.sv
module mac_ctl
  import mac_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic busy,
  output logic cap_en,
  output logic mul_en,
  output logic wr_en,
  output logic done
);
  mac_state_e state_q, state_d;
  logic       done_q, done_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (req) state_d = ST_MULT;
      ST_MULT:  state_d = ST_WRITE;
      ST_WRITE: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  assign busy   = (state_q != ST_IDLE);
  assign cap_en = (state_q == ST_IDLE) && req;
  assign mul_en = (state_q == ST_MULT);
  assign wr_en  = (state_q == ST_WRITE);
  assign done_d = wr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  assign done = done_q;
endmodule

// File: rtl/mac_mul.sv
module mac_mul
  import mac_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int SHORT_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  logic [3:0]            op,
  input  logic [WORD_W-1:0]     a,
  input  logic [WORD_W-1:0]     b,
  output logic [2*WORD_W-1:0]   prod
);
  localparam int EXT_W = WORD_W + 1;
  localparam int PAD_W = EXT_W - SHORT_W;

  logic signed [EXT_W-1:0]   xa, xb;
  logic signed [2*EXT_W-1:0] full;
  logic [2*WORD_W-1:0]       prod_q, prod_d;

  // Operand extension: sign or zero, short or full width
  always_comb begin
    case (op)
      OP_MAC16, OP_MULS16: begin
        xa = {{PAD_W{a[SHORT_W-1]}}, a[SHORT_W-1:0]};
        xb = {{PAD_W{b[SHORT_W-1]}}, b[SHORT_W-1:0]};
      end
      OP_MULU16: begin
        xa = {{PAD_W{1'b0}}, a[SHORT_W-1:0]};
        xb = {{PAD_W{1'b0}}, b[SHORT_W-1:0]};
      end
      OP_DMULU: begin
        xa = {1'b0, a};
        xb = {1'b0, b};
      end
      default: begin
        xa = {a[WORD_W-1], a};
        xb = {b[WORD_W-1], b};
      end
    endcase
  end

  assign full   = xa * xb;
  assign prod_d = en ? full[2*WORD_W-1:0] : prod_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prod_q <= '0;
    else        prod_q <= prod_d;
  end

  assign prod = prod_q;
endmodule

// File: rtl/mac_upd.sv
module mac_upd
  import mac_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int SAT_W  = 48
) (
  input  logic [3:0]          op,
  input  logic                sat,
  input  logic [WORD_W-1:0]   ld_data,
  input  logic [2*WORD_W-1:0] prod,
  input  logic [2*WORD_W-1:0] acc,
  output logic [2*WORD_W-1:0] acc_nxt
);
  localparam int ACC_W  = 2 * WORD_W;
  localparam int W16_W  = WORD_W + 2;
  localparam int W32_W  = ACC_W + 2;
  localparam int HI48_Z = W32_W - SAT_W + 1;

  localparam logic signed [W16_W-1:0] LIM16_MAX = {3'b000, {(WORD_W-1){1'b1}}};
  localparam logic signed [W16_W-1:0] LIM16_MIN = {3'b111, {(WORD_W-1){1'b0}}};
  localparam logic signed [W32_W-1:0] LIM48_MAX = {{HI48_Z{1'b0}}, {(SAT_W-1){1'b1}}};
  localparam logic signed [W32_W-1:0] LIM48_MIN = {{HI48_Z{1'b1}}, {(SAT_W-1){1'b0}}};
  localparam logic [WORD_W-1:0]       MARK_HI   = WORD_W'(1);

  logic [WORD_W-1:0]        hi, lo;
  logic signed [W16_W-1:0]  sum16;
  logic signed [W32_W-1:0]  sum32;
  logic [ACC_W-1:0]         wrap_sum;
  logic [ACC_W-1:0]         mac16_res, mac32_res;

  assign hi       = acc[ACC_W-1:WORD_W];
  assign lo       = acc[WORD_W-1:0];
  assign wrap_sum = acc + prod;
  assign sum16    = $signed({{2{lo[WORD_W-1]}}, lo}) +
                    $signed({{2{prod[WORD_W-1]}}, prod[WORD_W-1:0]});
  assign sum32    = $signed({{2{acc[ACC_W-1]}}, acc}) +
                    $signed({{2{prod[ACC_W-1]}}, prod});

  // Short MAC: 32-bit clamp with marker in the upper word
  always_comb begin
    if (!sat)                   mac16_res = wrap_sum;
    else if (sum16 > LIM16_MAX) mac16_res = {MARK_HI, LIM16_MAX[WORD_W-1:0]};
    else if (sum16 < LIM16_MIN) mac16_res = {MARK_HI, LIM16_MIN[WORD_W-1:0]};
    else                        mac16_res = {hi, sum16[WORD_W-1:0]};
  end

  // Long MAC: clamp to SAT_W-bit signed range
  always_comb begin
    if (!sat)                   mac32_res = wrap_sum;
    else if (sum32 > LIM48_MAX) mac32_res = LIM48_MAX[ACC_W-1:0];
    else if (sum32 < LIM48_MIN) mac32_res = LIM48_MIN[ACC_W-1:0];
    else                        mac32_res = sum32[ACC_W-1:0];
  end

  always_comb begin
    case (op)
      OP_CLR:                       acc_nxt = '0;
      OP_LDH:                       acc_nxt = {ld_data, lo};
      OP_LDL:                       acc_nxt = {hi, ld_data};
      OP_MAC16:                     acc_nxt = mac16_res;
      OP_MAC32:                     acc_nxt = mac32_res;
      OP_MUL32, OP_MULS16, OP_MULU16: acc_nxt = {hi, prod[WORD_W-1:0]};
      OP_DMULS, OP_DMULU:           acc_nxt = prod;
      default:                      acc_nxt = acc;
    endcase
  end
endmodule

// File: rtl/mac_unit.sv
module mac_unit
  import mac_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int SHORT_W = 16,
  parameter int SAT_W   = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [3:0]        op_code,
  input  logic              sat_mode,
  input  logic [WORD_W-1:0] op_a,
  input  logic [WORD_W-1:0] op_b,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] acc_hi,
  output logic [WORD_W-1:0] acc_lo
);
  localparam int ACC_W = 2 * WORD_W;

  logic [1:0]        rst_sync_q;
  logic              core_rst_n;
  logic              cap_en, mul_en, wr_en;
  logic [3:0]        op_q, op_d;
  logic              sat_q, sat_d;
  logic [WORD_W-1:0] a_q, a_d, b_q, b_d;
  logic [ACC_W-1:0]  prod, acc_q, acc_d, acc_upd;

  // Reset: asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  mac_ctl u_ctl (
    .clk    (clk),
    .rst_n  (core_rst_n),
    .req    (op_valid),
    .busy   (busy),
    .cap_en (cap_en),
    .mul_en (mul_en),
    .wr_en  (wr_en),
    .done   (done)
  );

  // Request capture
  assign op_d  = cap_en ? op_code  : op_q;
  assign sat_d = cap_en ? sat_mode : sat_q;
  assign a_d   = cap_en ? op_a     : a_q;
  assign b_d   = cap_en ? op_b     : b_q;

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      op_q  <= '0;
      sat_q <= 1'b0;
      a_q   <= '0;
      b_q   <= '0;
    end else begin
      op_q  <= op_d;
      sat_q <= sat_d;
      a_q   <= a_d;
      b_q   <= b_d;
    end
  end

  mac_mul #(.WORD_W(WORD_W), .SHORT_W(SHORT_W)) u_mul (
    .clk   (clk),
    .rst_n (core_rst_n),
    .en    (mul_en),
    .op    (op_q),
    .a     (a_q),
    .b     (b_q),
    .prod  (prod)
  );

  mac_upd #(.WORD_W(WORD_W), .SAT_W(SAT_W)) u_upd (
    .op      (op_q),
    .sat     (sat_q),
    .ld_data (a_q),
    .prod    (prod),
    .acc     (acc_q),
    .acc_nxt (acc_upd)
  );

  // Accumulator
  assign acc_d = wr_en ? acc_upd : acc_q;

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) acc_q <= '0;
    else             acc_q <= acc_d;
  end

  assign acc_hi = acc_q[ACC_W-1:WORD_W];
  assign acc_lo = acc_q[WORD_W-1:0];
endmodule

// File: rtl/mac_unit_chk.sv
module mac_unit_chk #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic [WORD_W-1:0] acc_hi,
  input logic [WORD_W-1:0] acc_lo
);
  a_r1_clear_on_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (acc_hi == '0) && (acc_lo == '0) && !busy && !done);

  a_r2_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r2_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy));

  a_r2_busy_two_cycles: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> busy);

  a_r12_acc_moves_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({acc_hi, acc_lo}) |-> done);
endmodule

bind mac_unit mac_unit_chk #(.WORD_W(WORD_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .busy   (busy),
  .done   (done),
  .acc_hi (acc_hi),
  .acc_lo (acc_lo)
);

// File: tb/sim_mac_unit.sv
`timescale 1ns/1ps
module sim_mac_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic [3:0]  op_code;
  logic        sat_mode;
  logic [31:0] op_a, op_b;
  logic        busy, done;
  logic [31:0] acc_hi, acc_lo;

  int n_cmp = 0;
  int n_bad = 0;
  logic [63:0] acc_m = '0;
  logic [63:0] exp_q[$];
  int          req_q[$];

  always #5 clk = ~clk;

  mac_unit u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .sat_mode(sat_mode), .op_a(op_a), .op_b(op_b), .busy(busy),
    .done(done), .acc_hi(acc_hi), .acc_lo(acc_lo)
  );

  task automatic check(input bit ok, input int req, input logic [63:0] act,
                       input logic [63:0] exp, input string what);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Reference model written from the requirements
  function automatic logic [63:0] model(input logic [3:0] op, input bit s,
      input logic [31:0] a, input logic [31:0] b, input logic [63:0] acc);
    longint p16, t, pl;
    logic signed [65:0] w;
    logic [31:0] u16;
    p16 = longint'($signed(a[15:0])) * longint'($signed(b[15:0]));
    pl  = longint'($signed(a)) * longint'($signed(b));
    u16 = {16'h0, a[15:0]} * {16'h0, b[15:0]};
    case (op)
      4'd0: return 64'h0;
      4'd1: return {a, acc[31:0]};
      4'd2: return {acc[63:32], a};
      4'd3: begin
        if (!s) return acc + 64'(p16);
        t = longint'($signed(acc[31:0])) + p16;
        if (t > 64'sh7FFFFFFF) return {32'd1, 32'h7FFFFFFF};
        if (t < -64'sh80000000) return {32'd1, 32'h80000000};
        return {acc[63:32], t[31:0]};
      end
      4'd4: begin
        if (!s) return acc + 64'(pl);
        w = $signed({{2{acc[63]}}, acc}) + 66'(pl);
        if (w > 66'sh00007FFFFFFFFFFF) return 64'h00007FFFFFFFFFFF;
        if (w < -66'sh800000000000)    return 64'hFFFF800000000000;
        return w[63:0];
      end
      4'd5: return {acc[63:32], a * b};
      4'd6: return {acc[63:32], p16[31:0]};
      4'd7: return {acc[63:32], u16};
      4'd8: return 64'(pl);
      4'd9: return {32'h0, a} * {32'h0, b};
      default: return acc;
    endcase
  endfunction

  // Driver: called at a falling edge, returns at a falling edge
  task automatic issue(input logic [3:0] op, input bit s, input logic [31:0] a,
                       input logic [31:0] b, input int req, input bit hold);
    while (busy) @(negedge clk);
    op_valid = 1'b1; op_code = op; sat_mode = s; op_a = a; op_b = b;
    acc_m = model(op, s, a, b, acc_m);
    exp_q.push_back(acc_m);
    req_q.push_back(req);
    @(negedge clk);
    if (hold) begin
      // R3: a clear request held during busy must be ignored
      op_code = 4'd0; sat_mode = 1'b0; op_a = '0;
      @(negedge clk);
    end
    op_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy || done) @(negedge clk);
  endtask

  // Monitor
  always @(negedge clk) begin
    if (rst_n === 1'b1 && done === 1'b1) begin
      if (exp_q.size() == 0) begin
        check(1'b0, 3, {acc_hi, acc_lo}, 64'h0, "unexpected done");
      end else begin
        logic [63:0] e;
        int r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        check({acc_hi, acc_lo} === e, r, {acc_hi, acc_lo}, e, "result");
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R2 watchdog expired: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; op_valid = 1'b0; op_code = '0; sat_mode = 1'b0; op_a = '0; op_b = '0;
    repeat (5) @(negedge clk);
    // R1: state during reset
    check({acc_hi, acc_lo} == 64'h0 && !busy && !done, 1, {acc_hi, acc_lo}, 64'h0, "in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check({acc_hi, acc_lo} == 64'h0 && !busy && !done, 1, {acc_hi, acc_lo}, 64'h0, "after reset");

    // R2: latency and busy window, checked cycle by cycle
    op_valid = 1'b1; op_code = 4'd2; sat_mode = 1'b0; op_a = 32'hA5A5_0001; op_b = '0;
    acc_m = model(4'd2, 1'b0, 32'hA5A5_0001, 32'h0, acc_m);
    exp_q.push_back(acc_m); req_q.push_back(10);
    @(negedge clk); op_valid = 1'b0;
    check(busy && !done, 2, {62'h0, busy, done}, 64'h2, "cycle 1 busy");
    @(negedge clk);
    check(busy && !done, 2, {62'h0, busy, done}, 64'h2, "cycle 2 busy");
    @(negedge clk);
    check(!busy && done, 2, {62'h0, busy, done}, 64'h1, "cycle 3 done");
    @(negedge clk);
    check(!done, 2, {63'h0, done}, 64'h0, "done one cycle");

    // R10: loads and clear, back to back
    issue(4'd1, 1'b0, 32'h1234_5678, 32'h0, 10, 1'b0);
    issue(4'd2, 1'b0, 32'h0000_0010, 32'h0, 10, 1'b0);
    // R4: short MAC without saturation, negative product
    issue(4'd3, 1'b0, 32'h0000_FFFF, 32'h0000_0003, 4, 1'b0);
    issue(4'd3, 1'b0, 32'hDEAD_8000, 32'hBEEF_8000, 4, 1'b0);
    // R6: in-range saturating keeps upper word
    issue(4'd3, 1'b1, 32'h0000_0100, 32'h0000_0100, 6, 1'b0);
    // R5: positive clamp
    issue(4'd2, 1'b0, 32'h7FFF_FFF0, 32'h0, 10, 1'b0);
    issue(4'd3, 1'b1, 32'h0000_0100, 32'h0000_0100, 5, 1'b0);
    // R6: negative clamp
    issue(4'd1, 1'b0, 32'h0000_0055, 32'h0, 10, 1'b0);
    issue(4'd2, 1'b0, 32'h8000_0010, 32'h0, 10, 1'b0);
    issue(4'd3, 1'b1, 32'h0000_FF00, 32'h0000_0100, 6, 1'b0);
    // R7: long MAC wrap and both clamps
    issue(4'd1, 1'b0, 32'h7FFF_FFFF, 32'h0, 10, 1'b0);
    issue(4'd2, 1'b0, 32'hFFFF_FFFF, 32'h0, 10, 1'b0);
    issue(4'd4, 1'b0, 32'h0000_0001, 32'h0000_0001, 7, 1'b0);
    issue(4'd1, 1'b0, 32'h0000_7FFF, 32'h0, 10, 1'b0);
    issue(4'd2, 1'b0, 32'hFFFF_0000, 32'h0, 10, 1'b0);
    issue(4'd4, 1'b1, 32'h0001_0000, 32'h0001_0000, 7, 1'b0);
    issue(4'd0, 1'b0, 32'h0, 32'h0, 10, 1'b0);
    issue(4'd4, 1'b1, 32'h8000_0000, 32'h7FFF_FFFF, 7, 1'b0);
    issue(4'd4, 1'b1, 32'h0000_1234, 32'hFFFF_FFFE, 7, 1'b0);
    // R8: multiply-only forms keep upper word
    issue(4'd1, 1'b0, 32'hCAFE_F00D, 32'h0, 10, 1'b0);
    issue(4'd5, 1'b0, 32'hFFFF_FFFF, 32'h0000_0007, 8, 1'b0);
    issue(4'd7, 1'b0, 32'h0000_FFFF, 32'h0000_FFFF, 8, 1'b0);
    issue(4'd6, 1'b0, 32'h0000_FFFF, 32'h0000_FFFF, 8, 1'b0);
    // R9: full-width multiplies
    issue(4'd9, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 9, 1'b0);
    issue(4'd8, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 9, 1'b0);
    issue(4'd8, 1'b0, 32'h8000_0000, 32'h0000_0002, 9, 1'b0);
    // R11: unused codes
    issue(4'd12, 1'b1, 32'h1111_1111, 32'h2222_2222, 11, 1'b0);
    issue(4'd15, 1'b0, 32'h3333_3333, 32'h4444_4444, 11, 1'b0);
    // R3: request held through busy is ignored
    issue(4'd3, 1'b0, 32'h0000_0002, 32'h0000_0003, 3, 1'b1);
    wait_idle();
    repeat (3) @(negedge clk);
    check({acc_hi, acc_lo} === acc_m, 3, {acc_hi, acc_lo}, acc_m, "no effect of held request");
    // R12: outputs steady while idle
    check({acc_hi, acc_lo} === acc_m && !done, 12, {acc_hi, acc_lo}, acc_m, "idle hold");
    check(exp_q.size() == 0, 2, 64'(exp_q.size()), 64'h0, "all results returned");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule